// File: doc/BRIEF.md
# Transceiver Power-Up and Lock Sequencer

This block drives one serial transceiver channel from power-valid to a locked receiver. It counts reference-clock cycles against a fixed microsecond schedule. The schedule runs in this order: a power-on hold, a bias-settling phase with the PLL pinned at its lowest frequency, a PLL and analog lock-in phase, and a data lock-in phase. At the end of the schedule it declares the receiver locked and enables comma detection. Every phase boundary is given in nanoseconds and converted to whole reference cycles at elaboration time, from a reference-frequency parameter.

The channel reset, sleep request, PLL bypass and lock-to-reference controls are asynchronous. Each passes through a two-flop synchroniser before the controller uses it. An asserted channel reset forces the PLL to minimum frequency, forces the serial output to zero, freezes the receive data, and clears the phase selector and the digital loop filter. Sleep powers the PLL down. Bypass parks the controller. Leaving any of these three states replays the whole lock-in schedule. When the lock-to-reference input drops after lock, the receiver goes idle. When that input returns, a short relock window runs and lock is declared again without the full schedule.

Top module: `xcvr_lock_seq`

## Requirements
- R1: While `rst_n` is low, and for C_HOLD reference cycles after it is released (20 µs by default, rounded up), every reset strobe is high: `pll_force_min`, `ser_out_zero`, `rx_hold`, `phase_sel_rst` and `loop_filt_rst`. During this time `rx_locked`, `comma_det_en` and `pll_pwr_dn` are low.
- R2: The bias phase lasts C_BIAS cycles (32 µs). Only `pll_force_min`, `rx_hold`, `phase_sel_rst` and `loop_filt_rst` are high during it.
- R3: From C_BIAS to C_ALOCK cycles into the schedule (262 µs), `pll_force_min` is low. `rx_hold`, `phase_sel_rst` and `loop_filt_rst` stay high.
- R4: From C_ALOCK to C_LOCK cycles (358 µs), the phase selector and loop filter are released. `rx_hold` stays high.
- R5: After C_LOCK cycles, if the synchronised lock-to-reference input is high, `rx_locked` and `comma_det_en` go high and every other output goes low.
- R6: The lock-to-reference input `lockref_n` is low when the receiver is to be idle. A low level seen three cycles after it is driven drops lock and raises `rx_hold`. A return to high starts a relock window of C_RELOCK cycles (2 µs); lock is declared again at its end. A drop inside the window restarts it. A low level at the end of the schedule gives idle instead of lock.
- R7: A low `dev_reset_n` forces the R1 strobe pattern three cycles after it is driven. It takes priority over sleep and bypass.
- R8: Releasing `dev_reset_n` restarts the full schedule from the bias phase three cycles later, provided sleep and bypass are inactive.
- R9: A high `sleep_req` raises `pll_pwr_dn` and `rx_hold`, `phase_sel_rst` and `loop_filt_rst` three cycles later. Lock is dropped.
- R10: Leaving sleep replays the full schedule from the bias phase.
- R11: A high `pll_bypass` parks the controller with only `rx_hold`, `phase_sel_rst` and `loop_filt_rst` high, for as long as it stays high. Releasing it replays the full schedule.
- R12: Each phase length is ceil(ns × REF_KHZ / 10^6) cycles. Each asynchronous input acts through exactly two synchronising flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low power-valid reset |
| dev_reset_n | input | 1 | Asynchronous active-low channel reset |
| sleep_req | input | 1 | Asynchronous low-power request |
| pll_bypass | input | 1 | PLL bypass; holds the schedule off |
| lockref_n | input | 1 | Asynchronous active-low lock-to-reference |
| pll_force_min | output | 1 | Pin PLL at minimum frequency |
| ser_out_zero | output | 1 | Force serial output to logic 0 |
| rx_hold | output | 1 | Freeze receive data at its last value |
| phase_sel_rst | output | 1 | Reset phase selection |
| loop_filt_rst | output | 1 | Reset digital loop filter |
| rx_locked | output | 1 | Receiver locked to data |
| comma_det_en | output | 1 | Enable comma detection |
| pll_pwr_dn | output | 1 | Power down the PLL |

## Verification
The hardest situation to reach is a lock-to-reference drop that arrives while the schedule is still running, or inside the short relock window. These events need exact cycle placement relative to internal phase boundaries that the ports never show. The bench computes every boundary from the rounded cycle counts and its own record of when each input was driven. It then lowers `lockref_n` part-way through a replayed schedule and pulses it inside a relock window. The scoreboard expects no lock at the schedule end and a restarted relock window.

// File: rtl/xls_pkg.sv
// Package: shared state type and the time-to-cycle conversion for the lock sequencer.
// Assumes times in nanoseconds and reference frequency in kHz.
package xls_pkg;

    typedef enum logic [3:0] {
        S_PORHOLD,
        S_DRESET,
        S_SLEEP,
        S_WAIT,
        S_BIAS,
        S_ALOCK,
        S_DLOCK,
        S_LOCKED,
        S_IDLE,
        S_RELOCK
    } seq_state_t;

    // Converts a duration to reference cycles, rounding any fraction up.
    function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                              input longint unsigned khz);
        longint unsigned prod;
        prod = ns * khz + 64'd999_999;
        return 32'(prod / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/xls_sync2.sv
// Two-flop synchroniser, one chain per bit.
// Assumes each input bit is independent; multi-bit coherence is not needed.
module xls_sync2 #(
    parameter int            W       = 4,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // Shift the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end

endmodule

// File: rtl/xls_phase_timer.sv
// Phase timer: counts reference cycles from the last clear and saturates at all-ones.
// Assumes the caller clears it on every phase entry that needs a fresh count.
module xls_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CMAX = '1;

    // Count up, clear on request, hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != CMAX)
            cnt <= cnt + W'(1);
    end

    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != CMAX) |=> (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/xcvr_lock_seq.sv
// Power-up and lock sequencer for one transceiver channel.
// Steps through hold, bias settle, analog lock and data lock on one shared timer,
// and decodes the phase into control strobes. Assumes clk is the reference clock
// at REF_KHZ and that every duration fits the derived counter width.
module xcvr_lock_seq #(
    parameter int unsigned REF_KHZ     = 125000,
    parameter int unsigned T_HOLD_NS   = 20000,
    parameter int unsigned T_BIAS_NS   = 32000,
    parameter int unsigned T_ALOCK_NS  = 262000,
    parameter int unsigned T_LOCK_NS   = 358000,
    parameter int unsigned T_RELOCK_NS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_reset_n,
    input  logic sleep_req,
    input  logic pll_bypass,
    input  logic lockref_n,
    output logic pll_force_min,
    output logic ser_out_zero,
    output logic rx_hold,
    output logic phase_sel_rst,
    output logic loop_filt_rst,
    output logic rx_locked,
    output logic comma_det_en,
    output logic pll_pwr_dn
);
    import xls_pkg::*;

    localparam int unsigned C_HOLD   = ns_to_cyc(T_HOLD_NS, REF_KHZ);
    localparam int unsigned C_BIAS   = ns_to_cyc(T_BIAS_NS, REF_KHZ);
    localparam int unsigned C_ALOCK  = ns_to_cyc(T_ALOCK_NS, REF_KHZ);
    localparam int unsigned C_LOCK   = ns_to_cyc(T_LOCK_NS, REF_KHZ);
    localparam int unsigned C_RELOCK = ns_to_cyc(T_RELOCK_NS, REF_KHZ);
    localparam int unsigned C_M1     = (C_HOLD > C_LOCK) ? C_HOLD : C_LOCK;
    localparam int unsigned C_MAX    = (C_M1 > C_RELOCK) ? C_M1 : C_RELOCK;
    localparam int          CW       = $clog2(C_MAX + 1);

    logic [3:0]    sync_q;
    logic          drst_s, slp_s, byp_s, lref_s;
    logic [CW-1:0] tmr;
    logic          tmr_clr;
    seq_state_t    st, nxt, gate_st;

    xls_sync2 #(.W(4), .RST_VAL(4'b0000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dev_reset_n, sleep_req, pll_bypass, lockref_n}),
        .q     (sync_q)
    );

    assign drst_s = sync_q[3];
    assign slp_s  = sync_q[2];
    assign byp_s  = sync_q[1];
    assign lref_s = sync_q[0];

    xls_phase_timer #(.W(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr)
    );

    // Pick the parked state by priority, or start the schedule when all are clear.
    always_comb begin
        if (!drst_s)     gate_st = S_DRESET;
        else if (slp_s)  gate_st = S_SLEEP;
        else if (byp_s)  gate_st = S_WAIT;
        else             gate_st = S_BIAS;
    end

    // Next-state and timer-clear decisions.
    always_comb begin
        nxt     = st;
        tmr_clr = 1'b0;
        case (st)
            S_PORHOLD: begin
                if (tmr == CW'(C_HOLD - 1)) begin
                    nxt     = gate_st;
                    tmr_clr = 1'b1;
                end
            end
            S_DRESET, S_SLEEP, S_WAIT: begin
                nxt     = gate_st;
                tmr_clr = 1'b1;
            end
            default: begin
                if (gate_st != S_BIAS) begin
                    nxt     = gate_st;
                    tmr_clr = 1'b1;
                end else begin
                    case (st)
                        S_BIAS:   if (tmr == CW'(C_BIAS - 1))  nxt = S_ALOCK;
                        S_ALOCK:  if (tmr == CW'(C_ALOCK - 1)) nxt = S_DLOCK;
                        S_DLOCK:  if (tmr == CW'(C_LOCK - 1))
                                      nxt = lref_s ? S_LOCKED : S_IDLE;
                        S_LOCKED: if (!lref_s) nxt = S_IDLE;
                        S_IDLE: begin
                            if (lref_s) begin
                                nxt     = S_RELOCK;
                                tmr_clr = 1'b1;
                            end
                        end
                        S_RELOCK: begin
                            if (!lref_s)                        nxt = S_IDLE;
                            else if (tmr == CW'(C_RELOCK - 1))  nxt = S_LOCKED;
                        end
                        default: nxt = S_PORHOLD;
                    endcase
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_PORHOLD;
        else        st <= nxt;
    end

    // Decode the phase into control strobes.
    always_comb begin
        pll_force_min = 1'b0;
        ser_out_zero  = 1'b0;
        rx_hold       = 1'b0;
        phase_sel_rst = 1'b0;
        loop_filt_rst = 1'b0;
        rx_locked     = 1'b0;
        comma_det_en  = 1'b0;
        pll_pwr_dn    = 1'b0;
        case (st)
            S_PORHOLD, S_DRESET: begin
                pll_force_min = 1'b1;
                ser_out_zero  = 1'b1;
                rx_hold       = 1'b1;
                phase_sel_rst = 1'b1;
                loop_filt_rst = 1'b1;
            end
            S_SLEEP: begin
                pll_pwr_dn    = 1'b1;
                rx_hold       = 1'b1;
                phase_sel_rst = 1'b1;
                loop_filt_rst = 1'b1;
            end
            S_WAIT, S_ALOCK: begin
                rx_hold       = 1'b1;
                phase_sel_rst = 1'b1;
                loop_filt_rst = 1'b1;
            end
            S_BIAS: begin
                pll_force_min = 1'b1;
                rx_hold       = 1'b1;
                phase_sel_rst = 1'b1;
                loop_filt_rst = 1'b1;
            end
            S_DLOCK, S_IDLE, S_RELOCK: rx_hold = 1'b1;
            S_LOCKED: begin
                rx_locked    = 1'b1;
                comma_det_en = 1'b1;
            end
            default: ;
        endcase
    end

    a_r6_drop_on_lockref: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_locked && !lref_s) |=> !rx_locked);

    a_r5_lock_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_locked) |-> $past(lref_s));

    a_r7_reset_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !drst_s |=> (pll_force_min && ser_out_zero && rx_hold && !rx_locked));

    a_r9_sleep_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        (drst_s && slp_s && st != S_PORHOLD) |=> (pll_pwr_dn && !rx_locked));

    a_r11_bypass_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (drst_s && !slp_s && byp_s && st != S_PORHOLD) |=> (!rx_locked && !pll_force_min));

endmodule

// File: tb/xcvr_lock_seq_test.sv
// Scoreboard bench: driver tasks queue expected output vectors with the cycle they
// must appear in; a monitor compares each cycle and checks stability in between.
// Vector order: {pll_force_min, ser_out_zero, rx_hold, phase_sel_rst,
//                loop_filt_rst, rx_locked, comma_det_en, pll_pwr_dn}.
module xcvr_lock_seq_test;

    // REF_KHZ = 3300: hold 66, bias 106, analog 865, lock 1182, relock 7 (rounded up).
    localparam int K_HOLD   = 66;
    localparam int K_BIAS   = 106;
    localparam int K_ALOCK  = 865;
    localparam int K_LOCK   = 1182;
    localparam int K_RELOCK = 7;
    localparam int K_SYNC   = 3;

    localparam logic [7:0] V_RST  = 8'hF8;
    localparam logic [7:0] V_SLP  = 8'h39;
    localparam logic [7:0] V_PARK = 8'h38;
    localparam logic [7:0] V_BIAS = 8'hB8;
    localparam logic [7:0] V_DATA = 8'h20;
    localparam logic [7:0] V_LOCK = 8'h06;

    logic clk = 1'b0;
    logic rst_n, dev_reset_n, sleep_req, pll_bypass, lockref_n;
    logic pll_force_min, ser_out_zero, rx_hold, phase_sel_rst, loop_filt_rst;
    logic rx_locked, comma_det_en, pll_pwr_dn;
    logic [7:0] outv;

    typedef struct {
        int         at;
        logic [7:0] vec;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         armed = 1'b0;
    logic [7:0] cur_exp = V_RST;
    string      cur_tag = "R1";

    always #10 clk = ~clk;

    xcvr_lock_seq #(.REF_KHZ(3300)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_reset_n   (dev_reset_n),
        .sleep_req     (sleep_req),
        .pll_bypass    (pll_bypass),
        .lockref_n     (lockref_n),
        .pll_force_min (pll_force_min),
        .ser_out_zero  (ser_out_zero),
        .rx_hold       (rx_hold),
        .phase_sel_rst (phase_sel_rst),
        .loop_filt_rst (loop_filt_rst),
        .rx_locked     (rx_locked),
        .comma_det_en  (comma_det_en),
        .pll_pwr_dn    (pll_pwr_dn)
    );

    assign outv = {pll_force_min, ser_out_zero, rx_hold, phase_sel_rst,
                   loop_filt_rst, rx_locked, comma_det_en, pll_pwr_dn};

    // Cycle counter used by driver and monitor.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop due items and compare; otherwise the last expected value must hold.
    always @(negedge clk) begin
        if (armed) begin
            if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
                item_t it;
                it = sb_q.pop_front();
                cur_exp = it.vec;
                cur_tag = it.tag;
                n_cmp++;
                if (outv !== cur_exp) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d: got %h expected %h", cur_tag, cyc, outv, cur_exp);
                end
            end else if (outv !== cur_exp) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s (hold) cycle %0d: got %h expected %h", cur_tag, cyc, outv, cur_exp);
                cur_exp = outv;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_at(input int at, input logic [7:0] v, input string tag);
        item_t it;
        it.at = at; it.vec = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Queue the full schedule that starts with the bias phase at cycle b.
    task automatic sched(input int b, input bit locks, input string tag);
        expect_at(b,               V_BIAS, {tag, " R2 bias"});
        expect_at(b + K_BIAS,      V_PARK, {tag, " R3 R12 analog"});
        expect_at(b + K_ALOCK,     V_DATA, {tag, " R4 R12 data"});
        expect_at(b + K_LOCK,      locks ? V_LOCK : V_DATA,
                  locks ? {tag, " R5 R12 lock"} : {tag, " R6 no lock"});
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        step(5);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; dev_reset_n = 1'b1; sleep_req = 1'b0;
        pll_bypass = 1'b0; lockref_n = 1'b1;
        step(4);
        armed = 1'b1;

        // R1 power-on hold, then the full schedule to lock (R2..R5, R12).
        n = cyc;
        expect_at(n + 1, V_RST, "R1 reset state");
        expect_at(n + K_HOLD - 1, V_RST, "R1 hold end");
        rst_n = 1'b1;
        sched(n + K_HOLD, 1'b1, "R1");
        drain();

        // R6: drop and restore lock-to-reference.
        n = cyc; lockref_n = 1'b0;
        expect_at(n + K_SYNC, V_DATA, "R6 idle");
        step(20);
        n = cyc; lockref_n = 1'b1;
        expect_at(n + K_SYNC + K_RELOCK, V_LOCK, "R6 relock");
        drain();

        // R6: a drop inside the relock window restarts it.
        n = cyc; lockref_n = 1'b0;
        expect_at(n + K_SYNC, V_DATA, "R6 idle again");
        step(5); lockref_n = 1'b1;
        step(4); lockref_n = 1'b0;
        step(11);
        n = cyc; lockref_n = 1'b1;
        expect_at(n + K_SYNC + K_RELOCK, V_LOCK, "R6 relock restart");
        drain();

        // R7 channel reset; sleep raised under reset stays masked; R9 then R10.
        n = cyc; dev_reset_n = 1'b0;
        expect_at(n + K_SYNC, V_RST, "R7 reset strobes");
        step(10); sleep_req = 1'b1;
        step(10);
        n = cyc; dev_reset_n = 1'b1;
        expect_at(n + K_SYNC, V_SLP, "R7 R9 reset over sleep");
        step(20);
        n = cyc; sleep_req = 1'b0;
        sched(n + K_SYNC, 1'b1, "R10");
        drain();

        // R8: plain reset release replays the schedule.
        n = cyc; dev_reset_n = 1'b0;
        expect_at(n + K_SYNC, V_RST, "R7 reset from lock");
        step(12);
        n = cyc; dev_reset_n = 1'b1;
        sched(n + K_SYNC, 1'b1, "R8");
        drain();

        // R9: sleep from lock, then R10 replay on exit.
        n = cyc; sleep_req = 1'b1;
        expect_at(n + K_SYNC, V_SLP, "R9 sleep");
        step(30);
        n = cyc; sleep_req = 1'b0;
        sched(n + K_SYNC, 1'b1, "R10");
        drain();

        // R11: bypass parks past a full schedule length, then replays;
        // lock-to-reference low mid-schedule gives idle (R6), restored later.
        n = cyc; pll_bypass = 1'b1;
        expect_at(n + K_SYNC, V_PARK, "R11 park");
        step(1500);
        n = cyc; pll_bypass = 1'b0;
        sched(n + K_SYNC, 1'b0, "R11");
        step(300); lockref_n = 1'b0;
        drain();
        step(20);
        n = cyc; lockref_n = 1'b1;
        expect_at(n + K_SYNC + K_RELOCK, V_LOCK, "R6 lock after late ref");
        drain();

        step(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule